// File: doc/BRIEF.md
# Sprite Attribute Block Copy Engine

This block moves a fixed run of 160 bytes from a 256-byte page of the system address space into sprite attribute memory. The CPU starts a copy by presenting the high byte of the source address on the trigger input. The low byte is always zero. After a fixed start delay the engine reads one source byte and writes it to the next sprite-memory offset. It repeats this at a fixed cadence until the whole run is done. Both memories are outside the block. The engine drives a combinational read port toward the source and a write strobe toward sprite memory.

While a copy is in progress the engine stands between the CPU and the system bus. CPU accesses that would collide with the copy are masked. A masked read returns 0xFF and a masked write never reaches the bus. The conflicting address window depends on which 8 KiB region the source lies in. A model-select pin picks between two conflict tables, one for the older hardware model and one for the newer. Sprite memory itself is always masked during a copy. Accesses outside the window pass straight through.

The copy runs on a fixed cadence, so the source-read and sprite-write ports carry a valid strobe with no ready. The source must return its data in the same cycle as the strobe, and sprite memory must accept every strobe. Back-pressure is not supported. The CPU and bus sides are plain combinational passthrough pins.

Top module: `spr_dma_engine`

## Requirements
- R1: A trigger whose page byte is greater than 0xF1 is ignored. An idle engine stays idle, and a running copy carries on unchanged. Page 0xF1 is accepted.
- R2: If a trigger is sampled on clock edge T, sprite byte 0 is written on edge T+8. Byte k is written on edge T+8+4k. The write strobe is high for exactly one cycle per byte.
- R3: Byte k is read from source address {page,8'h00}+k and written to sprite offset k. The written data equals the source read data in the same cycle. Exactly 160 bytes are written per copy.
- R4: `busy` is high from the cycle after an accepted trigger through the cycle that carries the last write strobe, and low afterwards.
- R5: While busy, CPU accesses to 0xFE00–0xFE9F are masked. A read returns 0xFF with `bus_rd` low, and a write leaves `bus_wr` low.
- R6: With `newer_model`=0, while busy: source bits [15:13]=4 masks 0x8000–0x9FFF, and every other value masks 0xA000–0xFDFF.
- R7: With `newer_model`=1, while busy: source bits [15:13]=4 masks 0x8000–0x9FFF, 6 masks 0xC000–0xFDFF, and every other value masks 0xA000–0xBFFF.
- R8: Accesses outside the masked ranges, and all accesses while idle, pass through unchanged. This covers the strobes, address and write data toward the bus, and the bus read data back to the CPU.
- R9: An accepted trigger during a copy restarts the engine. It uses the new page, offset 0, the full length of 160 bytes and a fresh 8-cycle start delay.
- R10: After reset the engine is idle. No write or read strobe is raised and every CPU access passes through.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| newer_model | input | 1 | Selects the newer model's conflict table |
| trig_valid | input | 1 | Start strobe, one cycle |
| trig_page | input | 8 | Source page (address high byte) |
| busy | output | 1 | Copy in progress |
| src_rd_en | output | 1 | Source read strobe |
| src_rd_addr | output | 16 | Source read address |
| src_rd_data | input | 8 | Source read data, same cycle |
| spr_wr_en | output | 1 | Sprite memory write strobe |
| spr_wr_addr | output | 8 | Sprite memory offset |
| spr_wr_data | output | 8 | Sprite memory write data |
| cpu_rd | input | 1 | CPU read request |
| cpu_wr | input | 1 | CPU write request |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rdata | output | 8 | Read data returned to the CPU |
| bus_rd | output | 1 | Read strobe toward the bus |
| bus_wr | output | 1 | Write strobe toward the bus |
| bus_addr | output | 16 | Address toward the bus |
| bus_wdata | output | 8 | Write data toward the bus |
| bus_rdata | input | 8 | Bus read data |

## Verification
The masking results are combinational and are due in the same cycle as the CPU request. The state-dependent results change one register stage after a clock edge: the busy flag, the write strobe, and the source and destination addresses. A trigger seen on edge T first changes `busy` after T, and the first strobe appears in the cycle that ends at T+8. The bench drives inputs on the falling edge. It advances a behavioural countdown model on each rising edge and compares every output two time units after the falling edge. Each comparison is made against the model state from the edge just passed, so registered and combinational outputs are sampled in the cycle they are due.

// File: rtl/spr_dma_pkg.sv
package spr_dma_pkg;
  localparam int ADDR_W     = 16;
  localparam int DATA_W     = 8;
  localparam int XFER_LEN   = 160;
  localparam int START_DLY  = 8;
  localparam int BYTE_GAP   = 4;
  localparam logic [7:0] PAGE_LIMIT = 8'hF1;
  localparam logic [ADDR_W-1:0] SPR_LO = 16'hFE00;
  localparam logic [ADDR_W-1:0] SPR_HI = 16'hFEA0;
  localparam int REGION_N   = 8;

  typedef struct packed {
    logic [ADDR_W-1:0] lo;
    logic [ADDR_W-1:0] hi;
  } win_t;
endpackage

// File: rtl/spr_dma_seq.sv
module spr_dma_seq
  import spr_dma_pkg::*;
#(
  parameter int XLEN  = XFER_LEN,
  parameter int DLY   = START_DLY,
  parameter int GAP   = BYTE_GAP,
  parameter logic [7:0] PLIM = PAGE_LIMIT,
  localparam int IDX_W  = $clog2(XLEN),
  localparam int MAXW   = (DLY > GAP) ? DLY : GAP,
  localparam int WAIT_W = (MAXW > 2) ? $clog2(MAXW) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trig_valid,
  input  logic [7:0]        trig_page,
  output logic              active,
  output logic              fire,
  output logic [ADDR_W-1:0] src_addr,
  output logic [IDX_W-1:0]  dst_idx
);
  logic [7:0]        page_q;
  logic [IDX_W-1:0]  idx_q;
  logic [WAIT_W-1:0] wait_q;
  logic              act_q;
  logic              accept;
  logic              last_byte;

  assign accept    = trig_valid && (trig_page <= PLIM);
  assign fire      = act_q && (wait_q == '0);
  assign last_byte = (idx_q == IDX_W'(XLEN - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      page_q <= '0;
      idx_q  <= '0;
      wait_q <= '0;
    end else if (accept) begin
      act_q  <= 1'b1;
      page_q <= trig_page;
      idx_q  <= '0;
      wait_q <= WAIT_W'(DLY - 1);
    end else if (fire) begin
      idx_q  <= idx_q + 1'b1;
      wait_q <= WAIT_W'(GAP - 1);
      if (last_byte) act_q <= 1'b0;
    end else if (act_q) begin
      wait_q <= wait_q - 1'b1;
    end
  end

  assign active   = act_q;
  assign dst_idx  = idx_q;
  assign src_addr = {page_q, 8'h00} + {{(ADDR_W-IDX_W){1'b0}}, idx_q};
endmodule

// File: rtl/spr_dma_conflict.sv
module spr_dma_conflict
  import spr_dma_pkg::*;
(
  input  logic [2:0] region,
  input  logic       newer,
  output win_t       win
);
  win_t tab_old [REGION_N];
  win_t tab_new [REGION_N];

  for (genvar g = 0; g < REGION_N; g++) begin : g_tab
    if (g == 4) begin : g_vid
      assign tab_old[g] = '{lo: 16'h8000, hi: 16'hA000};
      assign tab_new[g] = '{lo: 16'h8000, hi: 16'hA000};
    end else if (g == 6) begin : g_wrk
      assign tab_old[g] = '{lo: 16'hA000, hi: 16'hFE00};
      assign tab_new[g] = '{lo: 16'hC000, hi: 16'hFE00};
    end else begin : g_ext
      assign tab_old[g] = '{lo: 16'hA000, hi: 16'hFE00};
      assign tab_new[g] = '{lo: 16'hA000, hi: 16'hC000};
    end
  end

  assign win = newer ? tab_new[region] : tab_old[region];
endmodule

// File: rtl/spr_dma_gate.sv
module spr_dma_gate
  import spr_dma_pkg::*;
(
  input  logic              active,
  input  win_t              win,
  input  logic              cpu_rd,
  input  logic              cpu_wr,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              bus_rd,
  output logic              bus_wr,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] bus_rdata
);
  logic in_win, in_spr, masked;

  always_comb begin
    in_win = (cpu_addr >= win.lo) && (cpu_addr < win.hi);
    in_spr = (cpu_addr >= SPR_LO) && (cpu_addr < SPR_HI);
    masked = active && (in_win || in_spr);
  end

  assign bus_rd    = cpu_rd && !masked;
  assign bus_wr    = cpu_wr && !masked;
  assign bus_addr  = cpu_addr;
  assign bus_wdata = cpu_wdata;
  assign cpu_rdata = masked ? {DATA_W{1'b1}} : bus_rdata;
endmodule

// File: rtl/spr_dma_engine.sv
module spr_dma_engine
  import spr_dma_pkg::*;
#(
  parameter int XLEN = XFER_LEN,
  parameter int DLY  = START_DLY,
  parameter int GAP  = BYTE_GAP,
  parameter logic [7:0] PLIM = PAGE_LIMIT,
  localparam int IDX_W = $clog2(XLEN)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        newer_model,
  input  logic        trig_valid,
  input  logic [7:0]  trig_page,
  output logic        busy,
  output logic        src_rd_en,
  output logic [15:0] src_rd_addr,
  input  logic [7:0]  src_rd_data,
  output logic        spr_wr_en,
  output logic [7:0]  spr_wr_addr,
  output logic [7:0]  spr_wr_data,
  input  logic        cpu_rd,
  input  logic        cpu_wr,
  input  logic [15:0] cpu_addr,
  input  logic [7:0]  cpu_wdata,
  output logic [7:0]  cpu_rdata,
  output logic        bus_rd,
  output logic        bus_wr,
  output logic [15:0] bus_addr,
  output logic [7:0]  bus_wdata,
  input  logic [7:0]  bus_rdata
);
  logic              active, fire;
  logic [15:0]       src_addr;
  logic [IDX_W-1:0]  dst_idx;
  win_t              win;

  spr_dma_seq #(.XLEN(XLEN), .DLY(DLY), .GAP(GAP), .PLIM(PLIM)) u_seq (
    .clk(clk), .rst_n(rst_n), .trig_valid(trig_valid), .trig_page(trig_page),
    .active(active), .fire(fire), .src_addr(src_addr), .dst_idx(dst_idx)
  );

  spr_dma_conflict u_map (
    .region(src_addr[15:13]), .newer(newer_model), .win(win)
  );

  spr_dma_gate u_gate (
    .active(active), .win(win),
    .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_rdata(cpu_rdata), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  assign busy        = active;
  assign src_rd_en   = fire;
  assign src_rd_addr = src_addr;
  assign spr_wr_en   = fire;
  assign spr_wr_addr = 8'(dst_idx);
  assign spr_wr_data = src_rd_data;
endmodule

// File: rtl/spr_dma_chk.sv
module spr_dma_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        trig_valid,
  input logic [7:0]  trig_page,
  input logic        busy,
  input logic        src_rd_en,
  input logic [15:0] src_rd_addr,
  input logic        spr_wr_en,
  input logic [7:0]  spr_wr_addr,
  input logic        cpu_rd,
  input logic        cpu_wr,
  input logic [15:0] cpu_addr,
  input logic [7:0]  cpu_rdata,
  input logic        bus_rd,
  input logic        bus_wr,
  input logic [7:0]  bus_rdata
);
  logic spr_hit;
  assign spr_hit = (cpu_addr >= 16'hFE00) && (cpu_addr < 16'hFEA0);

  a_r4_write_only_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
    spr_wr_en |-> busy);

  a_r2_single_cycle_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    spr_wr_en && !trig_valid |=> !spr_wr_en);

  a_r3_src_dst_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    spr_wr_en |-> (src_rd_en && src_rd_addr[7:0] == spr_wr_addr));

  a_r1_high_page_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && trig_valid && trig_page > 8'hF1 |=> !busy);

  a_r5_spr_read_masked: assert property (@(posedge clk) disable iff (!rst_n)
    busy && cpu_rd && spr_hit |-> (cpu_rdata == 8'hFF && !bus_rd));

  a_r5_spr_write_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    busy && cpu_wr && spr_hit |-> !bus_wr);

  a_r8_idle_passthrough: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (bus_rd == cpu_rd && bus_wr == cpu_wr && cpu_rdata == bus_rdata));
endmodule

bind spr_dma_engine spr_dma_chk u_chk (
  .clk(clk), .rst_n(rst_n), .trig_valid(trig_valid), .trig_page(trig_page),
  .busy(busy), .src_rd_en(src_rd_en), .src_rd_addr(src_rd_addr),
  .spr_wr_en(spr_wr_en), .spr_wr_addr(spr_wr_addr),
  .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr), .cpu_rdata(cpu_rdata),
  .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_rdata(bus_rdata)
);

// File: tb/sim_spr_dma_engine.sv
`timescale 1ns/1ps
module sim_spr_dma_engine;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n = 1'b0, newer_model = 1'b0, trig_valid = 1'b0;
  logic [7:0] trig_page = '0;
  logic busy, src_rd_en, spr_wr_en, bus_rd, bus_wr;
  logic [15:0] src_rd_addr, bus_addr;
  logic [7:0] src_rd_data, spr_wr_addr, spr_wr_data, cpu_rdata, bus_wdata, bus_rdata;
  logic cpu_rd = 1'b0, cpu_wr = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic [7:0] cpu_wdata = '0;

  assign src_rd_data = src_rd_addr[7:0] ^ src_rd_addr[15:8] ^ 8'h5A;
  assign bus_rdata   = bus_addr[7:0] + 8'h11;

  spr_dma_engine u0 (.*);

  int total = 0, bad = 0;
  bit chk_on = 0;

  // behavioural reference: countdown to next byte, byte index, page
  bit m_busy = 0;
  int m_left = 0, m_idx = 0, m_page = 0;
  int wr_seen = 0;

  task automatic check(input string tag, input bit ok, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit in_rng(input int a, input int lo, input int hi);
    return a >= lo && a < hi;
  endfunction

  function automatic bit ref_masked(input int a);
    int r;
    if (!m_busy) return 0;
    if (in_rng(a, 'hFE00, 'hFEA0)) return 1;
    r = m_page >> 5;
    if (r == 4) return in_rng(a, 'h8000, 'hA000);
    if (newer_model) return (r == 6) ? in_rng(a, 'hC000, 'hFE00) : in_rng(a, 'hA000, 'hC000);
    return in_rng(a, 'hA000, 'hFE00);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_left = 0; m_idx = 0;
    end else begin
      if (m_busy) begin
        if (m_left == 1) begin
          m_idx++;
          m_left = 4;
          if (m_idx == 160) m_busy = 0;
        end else m_left--;
      end
      if (trig_valid && trig_page <= 8'hF1) begin
        m_busy = 1; m_page = trig_page; m_idx = 0; m_left = 8;
      end
    end
  end

  always @(negedge clk) begin
    #2;
    if (chk_on) begin
      bit ew, mk;
      string tg;
      ew = m_busy && m_left == 1;
      check("R4 busy", busy == m_busy, busy, m_busy);
      check("R2 write strobe timing", spr_wr_en == ew, spr_wr_en, ew);
      if (spr_wr_en) wr_seen++;
      if (ew) begin
        check("R3 dest offset", spr_wr_addr == m_idx[7:0], spr_wr_addr, m_idx);
        check("R3 source addr", src_rd_addr == 16'(m_page * 256 + m_idx), src_rd_addr, m_page * 256 + m_idx);
        check("R3 data copy", spr_wr_data == (src_rd_data), spr_wr_data, src_rd_data);
      end
      mk = ref_masked(cpu_addr);
      if (!m_busy || !mk) tg = "R8 passthrough";
      else if (in_rng(cpu_addr, 'hFE00, 'hFEA0)) tg = "R5 sprite mask";
      else if (newer_model) tg = "R7 newer table";
      else tg = "R6 older table";
      check(tg, bus_rd == (cpu_rd && !mk), bus_rd, cpu_rd && !mk);
      check(tg, bus_wr == (cpu_wr && !mk), bus_wr, cpu_wr && !mk);
      check(tg, bus_addr == cpu_addr && bus_wdata == cpu_wdata, bus_addr, cpu_addr);
      if (cpu_rd)
        check(tg, cpu_rdata == (mk ? 8'hFF : cpu_addr[7:0] + 8'h11), cpu_rdata,
              mk ? 8'hFF : cpu_addr[7:0] + 8'h11);
    end
  end

  int step = 0;
  task automatic run(input int n);
    for (int i = 0; i < n; i++) begin
      int sel;
      logic [15:0] pat;
      @(negedge clk);
      trig_valid = 1'b0;
      sel = step % 12;
      case (sel)
        0: pat = 16'h0100;  1: pat = 16'h8100;  2: pat = 16'h9FFF;  3: pat = 16'hA000;
        4: pat = 16'hBFFF;  5: pat = 16'hC000;  6: pat = 16'hDFFF;  7: pat = 16'hFDFF;
        8: pat = 16'hFE00;  9: pat = 16'hFE9F;  10: pat = 16'hFEA0; default: pat = 16'hFF80;
      endcase
      cpu_addr  = pat;
      cpu_rd    = ((step / 12) % 2) == 0;
      cpu_wr    = ((step / 12) % 2) == 1;
      cpu_wdata = step[7:0];
      step++;
    end
  endtask

  task automatic fire_trig(input logic [7:0] pg);
    @(negedge clk);
    trig_valid = 1'b1;
    trig_page  = pg;
    if (pg <= 8'hF1) wr_seen = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #2;
    check("R10 reset busy", busy == 1'b0, busy, 0);
    check("R10 reset strobes", spr_wr_en == 1'b0 && src_rd_en == 1'b0, spr_wr_en, 0);
    @(negedge clk);
    rst_n = 1'b1;
    chk_on = 1;
    run(30);

    newer_model = 1'b0;
    fire_trig(8'h80); run(700);
    check("R3 byte count old/vid", wr_seen == 160, wr_seen, 160);
    fire_trig(8'hC0); run(700);
    check("R3 byte count old/wrk", wr_seen == 160, wr_seen, 160);
    fire_trig(8'h12); run(700);

    newer_model = 1'b1;
    fire_trig(8'h00); run(700);
    fire_trig(8'hC3); run(700);
    fire_trig(8'h9E); run(700);

    fire_trig(8'hF2); run(1);
    #2 check("R1 page above limit ignored", busy == 1'b0, busy, 0);
    run(20);
    fire_trig(8'hF1); run(1);
    #2 check("R1 page at limit accepted", busy == 1'b1, busy, 1);
    run(700);
    check("R3 byte count F1", wr_seen == 160, wr_seen, 160);

    fire_trig(8'h40); run(150);
    fire_trig(8'hFF); run(50);
    fire_trig(8'hA5); run(1);
    #2 check("R9 restart keeps busy", busy == 1'b1, busy, 1);
    run(700);
    check("R9 restart full length", wr_seen == 160, wr_seen, 160);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule